// File: doc/BRIEF.md
# Angular Rate Threshold Event Detector

This block watches a stream of three-axis signed angular-rate samples and raises an event on any axis whose rate magnitude stays above a programmable limit long enough. Each sample is reduced to a 7-bit unsigned magnitude and compared with the threshold. A per-axis debounce counter qualifies the comparison, so a single spike does not raise an event.

Two settings shape the result. The first is what a below-limit sample does to the counter: it either resets the counter or steps it down by one. The second is whether the flags follow the newest sample or stay set until software reads the source byte. The result is one source byte. It holds a flag and a sign bit for each axis, plus a summary bit that is set while any axis flag is set. A pulse that marks entry into the measuring state clears all of the detector's state.

Top module: `rt_event_det`

## Requirements
- R1: An axis sample counts as above the limit when its magnitude exceeds `thr_byte[6:0]`. The magnitude is |rate| shifted right by 8, for a 16-bit rate, and saturates at 127. A magnitude equal to the limit does not count as above.
- R2: Each above-limit sample adds one to the axis counter, which saturates at 255. An event occurs on an above-limit sample when the updated count is at least `dbnc_byte`. A debounce value of 0 or 1 therefore fires on the first above-limit sample.
- R3: When `thr_byte[7]` is 1, a below-limit sample resets the axis counter to 0.
- R4: When `thr_byte[7]` is 0, a below-limit sample lowers the axis counter by one, and the counter does not go below 0.
- R5: `cfg_byte[0]`, `cfg_byte[1]` and `cfg_byte[2]` enable the X, Y and Z axes. A disabled axis never raises an event, and its counter is held at 0.
- R6: The layout of `src_byte` is as follows. Bit 1 is the X event and bit 0 the X sign. Bit 3 is the Y event and bit 2 the Y sign. Bit 5 is the Z event and bit 4 the Z sign. Bit 6 is the OR of the three event bits, and bit 7 is 0. A sign bit of 1 means the triggering rate was negative, and a sign bit is never 1 while its event bit is 0.
- R7: When `cfg_byte[3]` is 0, each valid sample sets every axis event bit to that sample's event result and its sign bit to the sample's sign when it fires, or to 0 otherwise. In this mode `src_read` has no effect.
- R8: When `cfg_byte[3]` is 1, an event sets the axis bit and records the sign of the sample that first set it. Both stay until a `src_read` pulse clears them. An event in the same cycle as a read wins over the read.
- R9: A `go_active` pulse clears every counter and flag on the next clock edge, and takes priority over all other inputs.
- R10: After reset, `src_byte` is 0.
- R11: In a cycle with no `sample_valid`, no `src_read` and no `go_active`, the source byte does not change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sample_valid | input | 1 | The rate sample on `rate_in` is new this cycle |
| rate_in | input | 3*RATE_W | Signed rates, with X in the low bits, then Y, then Z |
| cfg_byte | input | 8 | Axis enables in bits 2:0 and the latch enable in bit 3 |
| thr_byte | input | 8 | Threshold in bits 6:0 and the debounce mode in bit 7 |
| dbnc_byte | input | CNT_W | Debounce count |
| src_read | input | 1 | Source byte read strobe |
| go_active | input | 1 | Pulse marking entry into the measuring state |
| src_byte | output | 8 | Event source byte |

## Verification
The bench drives a magnitude exactly at the threshold and one step above it, where an off-by-one compare would fire too early or too late. It also drives the most negative rate, whose magnitude would wrap to 0 without saturation and report no event. An above, above, below, above, above pattern with a debounce of three fires only in decrement mode, so swapping the two modes changes the event cycle. Latched runs issue reads in the same cycle as new events, and read while the axis flag is already set; a design that lets the read win, or that overwrites the recorded sign, loses or flips a flag. Random stimulus with enables toggling and `go_active` pulses checks that disabled axes stay quiet and that a restart leaves no stale counts.

// File: rtl/rt_pkg.sv
`timescale 1ns/1ps
package rt_pkg;
   localparam int NUM_AXES = 3;
   localparam int CFG_LATCH_BIT = 3;
   localparam int THR_MODE_BIT = 7;
   typedef struct packed {
      logic evt;
      logic pol;
   } axis_flag_t;
endpackage

// File: rtl/rt_mag_cmp.sv
`timescale 1ns/1ps
module rt_mag_cmp #(
   parameter int RATE_W = 16,
   parameter int THR_W = 7
) (
   input  logic [RATE_W-1:0] rate,
   input  logic [THR_W-1:0]  thr,
   output logic              above,
   output logic              sign
);
   logic [RATE_W-1:0] abs_v;
   logic [THR_W-1:0]  mag;

   if (RATE_W < 2) begin : g_bad_rate
      $error("rt_mag_cmp: RATE_W must be at least 2");
   end

   assign sign  = rate[RATE_W-1];
   assign abs_v = sign ? (~rate + 1'b1) : rate;

   if (RATE_W - 1 > THR_W) begin : g_scale_down
      localparam int SH = RATE_W - 1 - THR_W;
      logic [THR_W:0] shifted;
      assign shifted = abs_v[RATE_W-1:SH];
      assign mag = shifted[THR_W] ? '1 : shifted[THR_W-1:0];
   end else begin : g_extend
      logic [THR_W:0] ext;
      assign ext = (THR_W+1)'(abs_v);
      assign mag = ext[THR_W] ? '1 : ext[THR_W-1:0];
   end

   assign above = mag > thr;
endmodule

// File: rtl/rt_axis_dbnc.sv
`timescale 1ns/1ps
module rt_axis_dbnc #(
   parameter int CNT_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             go,
   input  logic             valid,
   input  logic             en,
   input  logic             above,
   input  logic             sign,
   input  logic             mode_clr,
   input  logic             latch,
   input  logic             read,
   input  logic [CNT_W-1:0] dbnc,
   output logic             evt,
   output logic             pol
);
   localparam logic [CNT_W-1:0] CNT_MAX = '1;

   if (CNT_W < 1) begin : g_bad_cnt
      $error("rt_axis_dbnc: CNT_W must be positive");
   end

   logic [CNT_W-1:0] cnt, cnt_inc, cnt_nxt;
   logic             fire;

   assign cnt_inc = (cnt == CNT_MAX) ? cnt : cnt + 1'b1;
   assign fire    = valid && en && above && (cnt_inc >= dbnc);

   always_comb begin
      cnt_nxt = cnt;
      if (go || !en)        cnt_nxt = '0;
      else if (valid) begin
         if (above)         cnt_nxt = cnt_inc;
         else if (mode_clr) cnt_nxt = '0;
         else if (cnt != '0) cnt_nxt = cnt - 1'b1;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt <= '0;
         evt <= 1'b0;
         pol <= 1'b0;
      end else begin
         cnt <= cnt_nxt;
         if (go) begin
            evt <= 1'b0;
            pol <= 1'b0;
         end else if (latch) begin
            if (fire) begin
               evt <= 1'b1;
               pol <= evt ? pol : sign;
            end else if (read) begin
               evt <= 1'b0;
               pol <= 1'b0;
            end
         end else if (valid) begin
            evt <= fire;
            pol <= fire & sign;
         end
      end
   end

   // R3
   clr_mode_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (valid && en && !above && mode_clr && !go) |=> (cnt == '0));
   // R4
   dec_mode_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (valid && en && !above && !mode_clr && !go && cnt != '0) |=>
      (cnt == CNT_W'($past(cnt) - 1'b1)));
   // R5
   dis_axis_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !en |=> (cnt == '0));
   // R6
   pol_needs_evt_chk: assert property (@(posedge clk) disable iff (!rst_n)
      pol |-> evt);
   // R8
   latch_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (latch && evt && !read && !go) |=> (evt && $stable(pol)));
   // R11
   idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!valid && !read && !go) |=> ($stable(evt) && $stable(pol)));
endmodule

// File: rtl/rt_event_det.sv
`timescale 1ns/1ps
module rt_event_det
   import rt_pkg::*;
#(
   parameter int RATE_W = 16,
   parameter int THR_W = 7,
   parameter int CNT_W = 8
) (
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic                       sample_valid,
   input  logic [NUM_AXES*RATE_W-1:0] rate_in,
   input  logic [7:0]                 cfg_byte,
   input  logic [7:0]                 thr_byte,
   input  logic [CNT_W-1:0]           dbnc_byte,
   input  logic                       src_read,
   input  logic                       go_active,
   output logic [7:0]                 src_byte
);
   if (THR_W > THR_MODE_BIT || THR_W < 1) begin : g_bad_thr
      $error("rt_event_det: THR_W must lie in 1..7");
   end

   axis_flag_t [NUM_AXES-1:0] flags;
   logic       [NUM_AXES-1:0] evts;

   for (genvar a = 0; a < NUM_AXES; a++) begin : g_axis
      logic above_a, sign_a;

      rt_mag_cmp #(.RATE_W(RATE_W), .THR_W(THR_W)) i_cmp (
         .rate  (rate_in[a*RATE_W +: RATE_W]),
         .thr   (thr_byte[THR_W-1:0]),
         .above (above_a),
         .sign  (sign_a)
      );

      rt_axis_dbnc #(.CNT_W(CNT_W)) i_dbnc (
         .clk      (clk),
         .rst_n    (rst_n),
         .go       (go_active),
         .valid    (sample_valid),
         .en       (cfg_byte[a]),
         .above    (above_a),
         .sign     (sign_a),
         .mode_clr (thr_byte[THR_MODE_BIT]),
         .latch    (cfg_byte[CFG_LATCH_BIT]),
         .read     (src_read),
         .dbnc     (dbnc_byte),
         .evt      (flags[a].evt),
         .pol      (flags[a].pol)
      );

      assign evts[a] = flags[a].evt;
   end

   assign src_byte = {1'b0, |evts, flags};

   // R9
   go_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
      go_active |=> (src_byte == 8'h00));
   // R6
   top_bit_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !src_byte[7]);
endmodule

// File: tb/test_rt_event_det.sv
`timescale 1ns/1ps
module test_rt_event_det;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        sample_valid = 1'b0;
   logic [47:0] rate_in = '0;
   logic [7:0]  cfg_byte = '0;
   logic [7:0]  thr_byte = '0;
   logic [7:0]  dbnc_byte = '0;
   logic        src_read = 1'b0;
   logic        go_active = 1'b0;
   logic [7:0]  src_byte;

   int vectors = 0;
   int errors = 0;
   bit done = 0;

   int m_cnt[3];
   bit m_evt[3];
   bit m_pol[3];

   always #5 clk = ~clk;

   rt_event_det i_rt_event_det (
      .clk(clk), .rst_n(rst_n), .sample_valid(sample_valid), .rate_in(rate_in),
      .cfg_byte(cfg_byte), .thr_byte(thr_byte), .dbnc_byte(dbnc_byte),
      .src_read(src_read), .go_active(go_active), .src_byte(src_byte)
   );

   // R1: magnitude reduction used by the reference
   function automatic int mag7(input logic [15:0] r);
      int v = int'($signed(r));
      int a = (v < 0) ? -v : v;
      a = a >>> 8;
      return (a > 127) ? 127 : a;
   endfunction

   function automatic logic [7:0] model_byte();
      logic [7:0] b = '0;
      for (int a = 0; a < 3; a++) begin
         b[2*a]   = m_pol[a];
         b[2*a+1] = m_evt[a];
      end
      b[6] = m_evt[0] | m_evt[1] | m_evt[2];
      return b;
   endfunction

   // Reference step: R2, R3, R4, R5, R7, R8, R9
   function automatic void model_step();
      for (int a = 0; a < 3; a++) begin
         logic [15:0] r = rate_in[a*16 +: 16];
         bit ab = mag7(r) > int'(thr_byte[6:0]);
         bit ev = 0;
         int inc = (m_cnt[a] == 255) ? 255 : m_cnt[a] + 1;
         if (go_active) begin
            m_cnt[a] = 0; m_evt[a] = 0; m_pol[a] = 0;
            continue;
         end
         if (!cfg_byte[a]) m_cnt[a] = 0;
         else if (sample_valid) begin
            ev = ab && (inc >= int'(dbnc_byte));
            if (ab) m_cnt[a] = inc;
            else if (thr_byte[7]) m_cnt[a] = 0;
            else if (m_cnt[a] > 0) m_cnt[a] = m_cnt[a] - 1;
         end
         if (cfg_byte[3]) begin
            if (ev) begin
               if (!m_evt[a]) m_pol[a] = r[15];
               m_evt[a] = 1;
            end else if (src_read) begin
               m_evt[a] = 0; m_pol[a] = 0;
            end
         end else if (sample_valid) begin
            m_evt[a] = ev;
            m_pol[a] = ev & r[15];
         end
      end
   endfunction

   task automatic check(input string tag, input logic [7:0] exp);
      vectors++;
      if (src_byte !== exp) begin
         errors++;
         $display("FAIL %s: src_byte actual %02h expected %02h", tag, src_byte, exp);
      end
   endtask

   task automatic apply(input bit v, input logic [15:0] x, input logic [15:0] y,
                        input logic [15:0] z, input bit rd, input bit go, input string tag);
      sample_valid = v;
      rate_in = {z, y, x};
      src_read = rd;
      go_active = go;
      @(posedge clk);
      model_step();
      @(negedge clk);
      check(tag, model_byte());
   endtask

   task automatic restart();
      cfg_byte = 8'h00;
      apply(0, 0, 0, 0, 0, 1, "R9 restart");
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         errors++;
         $display("FAIL watchdog: actual hung expected finish");
         $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
         $finish;
      end
   end

   initial begin
      int unsigned seed = $urandom(32'd2718);
      repeat (3) @(negedge clk);
      // R10
      check("R10 reset", 8'h00);
      rst_n = 1'b1;
      @(negedge clk);
      check("R10 after release", 8'h00);

      // R1: limit 64; magnitude 64 is not above, 65 is
      cfg_byte = 8'h01; thr_byte = 8'd64; dbnc_byte = 8'd0;
      apply(1, 16'd16384, 0, 0, 0, 0, "R1 equal");
      check("R1 equal no event", 8'h00);
      apply(1, 16'd16640, 0, 0, 0, 0, "R1 above");
      check("R1 above fires", 8'h42);
      apply(1, -16'sd16640, 0, 0, 0, 0, "R6 negative");
      check("R6 negative sign", 8'h43);

      // R1: most negative rate saturates to 127
      restart();
      cfg_byte = 8'h04; thr_byte = 8'd126;
      apply(1, 0, 0, 16'h8000, 0, 0, "R1 saturate");
      check("R1 saturate Z", 8'h70);

      // R3 / R4: above, above, below, above, above with debounce 3
      restart();
      cfg_byte = 8'h02; thr_byte = 8'h8A; dbnc_byte = 8'd3;
      apply(1, 0, 16'h7000, 0, 0, 0, "R3 s1");
      apply(1, 0, 16'h7000, 0, 0, 0, "R3 s2");
      apply(1, 0, 16'h0100, 0, 0, 0, "R3 s3");
      apply(1, 0, 16'h7000, 0, 0, 0, "R3 s4");
      apply(1, 0, 16'h7000, 0, 0, 0, "R3 s5");
      check("R3 clear mode no event", 8'h00);
      restart();
      cfg_byte = 8'h02; thr_byte = 8'h0A;
      apply(1, 0, 16'h7000, 0, 0, 0, "R4 s1");
      apply(1, 0, 16'h7000, 0, 0, 0, "R4 s2");
      apply(1, 0, 16'h0100, 0, 0, 0, "R4 s3");
      apply(1, 0, 16'h7000, 0, 0, 0, "R4 s4");
      check("R2 not yet", 8'h00);
      apply(1, 0, 16'h7000, 0, 0, 0, "R4 s5");
      check("R4 decrement mode fires", 8'h48);
      // R11
      apply(0, 0, 16'h0100, 0, 0, 0, "R11 idle");
      check("R11 idle hold", 8'h48);
      // R7: read ignored without latch
      apply(0, 0, 0, 0, 1, 0, "R7 read ignored");
      check("R7 read ignored", 8'h48);

      // R5: disabled axis never fires
      restart();
      cfg_byte = 8'h05; thr_byte = 8'd0; dbnc_byte = 8'd0;
      apply(1, 16'h7000, 16'h7000, 16'h7000, 0, 0, "R5 disabled Y");
      check("R5 disabled Y", 8'h62);

      // R8: latch, sign kept, event wins over read
      restart();
      cfg_byte = 8'h09; thr_byte = 8'd10; dbnc_byte = 8'd1;
      apply(1, -16'sd30000, 0, 0, 0, 0, "R8 set");
      apply(1, 16'd30000, 0, 0, 1, 0, "R8 event beats read");
      check("R8 sign kept", 8'h43);
      apply(1, 16'd0, 0, 0, 0, 0, "R8 below holds");
      check("R8 latched", 8'h43);
      apply(0, 0, 0, 0, 1, 0, "R8 read clears");
      check("R8 cleared", 8'h00);

      // R9: go wins over a firing sample
      apply(1, 16'd30000, 0, 0, 0, 1, "R9 go priority");
      check("R9 go priority", 8'h00);

      // Random mix: R2 R6 R7 R8 R9 R11
      for (int blk = 0; blk < 60; blk++) begin
         cfg_byte  = 8'($urandom_range(0, 15));
         thr_byte  = 8'($urandom_range(0, 255));
         dbnc_byte = 8'($urandom_range(0, 4));
         for (int i = 0; i < 50; i++) begin
            apply($urandom_range(0, 3) != 0, 16'($urandom), 16'($urandom), 16'($urandom),
                  $urandom_range(0, 9) == 0, $urandom_range(0, 49) == 0,
                  "random R2 R6 R7 R8");
         end
      end

      if (seed == 0) vectors = vectors + 0;
      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
      $finish;
   end
endmodule